// File: doc/BRIEF.md
# Programmable Slave Port Arbiter

This block decides which of eight bus masters owns one slave port of a multi-master crossbar. Each master raises its own request line. The arbiter grants one master, shown both as a one-hot vector and as an encoded index. It keeps that grant until the owner pulses transfer done, and only then chooses again.

Two 32-bit registers sit behind a small write/read interface. The level register gives every master a priority code. The control register picks fixed-priority or round-robin arbitration and decides what the port grants while it is idle. When idle, the port can park on a named master, park on the master granted last, or grant nobody. The control register also holds a lock bit. Once the lock is set, neither register can be written again until reset.

Top module: `slave_port_arbiter`

## Requirements
- R1: After reset the level register reads 0x66543210 (master m at level m, capped at 6), the control register reads 0, `gnt` is 8'h01 and `gnt_idx` is 0.
- R2: With `cfg_sel`=0, the level of master m sits in bits 4m+2..4m and bit 4m+3 reads 0. With `cfg_sel`=1, bit 31 is the lock, bit 8 is the mode (1 = round robin), bits 5:4 are the idle policy and bits 2:0 are the park master; every other bit reads 0.
- R3: In fixed mode, the requester with the numerically lowest level code wins (0 is highest). On a tie the lower-numbered master wins. A master at code 7 is never granted.
- R4: In round-robin mode, the winner is the first requester found when searching upward from the master after the last one granted, wrapping after 7. Levels are ignored. After reset the last granted master is 7.
- R5: While a master owns the port, its grant stays the same whatever the requests do, until a cycle with `xfer_done`=1. In that cycle the arbiter chooses again among the current requests, and the new grant appears after that clock edge.
- R6: On an idle port, a request sampled at a clock edge is granted right after that edge. Before that edge the outputs still show the idle value.
- R7: On an idle port, policy 00 drives the grant of the park master, policy 01 drives the grant of the last granted master, and policy 10 or 11 drives `gnt`=0.
- R8: A control write with bit 31 set stores the write and sets the lock. After that, writes to either register change nothing. Only reset clears the lock.
- R9: `gnt` is one-hot or zero, `gnt_idx` names the set bit, and `gnt_idx` is 0 when `gnt` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 = levels, 1 = control |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| req | input | 8 | Per-master request lines |
| xfer_done | input | 1 | The current owner finishes its transfer |
| gnt | output | 8 | One-hot grant |
| gnt_idx | output | 3 | Encoded grant index |

## Verification
The bench sweeps all 256 request patterns in fixed mode under three level maps: the reset map, a map with every master at the same level, and a map with several masters at the invalid code. A design that compared with `<=` would hand ties to the wrong master. A design that did not filter code 7 would grant a master that must stay silent. The same sweep in round-robin mode checks the wrap-around search from the bench's own record of the last grant; an off-by-one start point would fail almost every pattern there. The bench also checks that the grant does not move mid-transfer and that the idle policies drive the right grant. Once locked, later writes must leave both registers unchanged; a design that gated only one of the two registers would fail.

// File: rtl/spa_pkg.sv
package spa_pkg;
  // idle policy encodings of the control register
  localparam logic [1:0] POL_PARK_FIXED = 2'b00;
  localparam logic [1:0] POL_PARK_LAST  = 2'b01;
  // control register field positions
  localparam int unsigned CTL_MODE_BIT = 8;
  localparam int unsigned CTL_POL_LO   = 4;
  localparam int unsigned CTL_PARK_LO  = 0;
endpackage

// File: rtl/spa_regs.sv
module spa_regs #(
  parameter int unsigned NM     = 8,
  parameter int unsigned FW     = 4,
  parameter int unsigned LW     = 3,
  parameter int unsigned DW     = 32,
  localparam int unsigned IW    = $clog2(NM),
  localparam int unsigned LVMAX = (1 << LW) - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             sel,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic [NM*LW-1:0] levels,
  output logic             rr_mode,
  output logic [1:0]       policy,
  output logic [IW-1:0]    park_idx,
  output logic             locked
);
  import spa_pkg::*;
  localparam int unsigned LOCK_BIT = DW - 1;

  logic [NM*LW-1:0] lvl_q, lvl_d;
  logic             mode_q, mode_d, lock_q, lock_d;
  logic [1:0]       pol_q, pol_d;
  logic [IW-1:0]    park_q, park_d;
  logic             lvl_en, ctl_en;

  function automatic logic [LW-1:0] rst_level(int unsigned m);
    return (m > LVMAX) ? LW'(LVMAX) : LW'(m);
  endfunction

  assign lvl_en = wr_en && !lock_q && !sel;
  assign ctl_en = wr_en && !lock_q && sel;

  always_comb begin
    for (int m = 0; m < NM; m++) lvl_d[m*LW +: LW] = wdata[m*FW +: LW];
    mode_d = wdata[CTL_MODE_BIT];
    pol_d  = wdata[CTL_POL_LO +: 2];
    park_d = wdata[CTL_PARK_LO +: IW];
    lock_d = wdata[LOCK_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int m = 0; m < NM; m++) lvl_q[m*LW +: LW] <= rst_level(m);
    end else if (lvl_en) begin
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      pol_q  <= POL_PARK_FIXED;
      park_q <= '0;
      lock_q <= 1'b0;
    end else if (ctl_en) begin
      mode_q <= mode_d;
      pol_q  <= pol_d;
      park_q <= park_d;
      lock_q <= lock_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (!sel) begin
      for (int m = 0; m < NM; m++) rdata[m*FW +: LW] = lvl_q[m*LW +: LW];
    end else begin
      rdata[LOCK_BIT]           = lock_q;
      rdata[CTL_MODE_BIT]       = mode_q;
      rdata[CTL_POL_LO +: 2]    = pol_q;
      rdata[CTL_PARK_LO +: IW]  = park_q;
    end
  end

  assign levels   = lvl_q;
  assign rr_mode  = mode_q;
  assign policy   = pol_q;
  assign park_idx = park_q;
  assign locked   = lock_q;
endmodule

// File: rtl/spa_pick.sv
module spa_pick #(
  parameter int unsigned NM  = 8,
  parameter int unsigned LW  = 3,
  localparam int unsigned IW = $clog2(NM)
) (
  input  logic [NM-1:0]    req,
  input  logic [NM*LW-1:0] levels,
  input  logic             rr_mode,
  input  logic [IW-1:0]    last,
  output logic             found,
  output logic [IW-1:0]    win
);
  localparam logic [LW-1:0] LV_BAD = '1;

  logic          fx_found, rr_found;
  logic [IW-1:0] fx_win, rr_win;
  logic [LW-1:0] best;

  // fixed: strict less-than keeps the lowest index on ties
  always_comb begin
    fx_found = 1'b0;
    fx_win   = '0;
    best     = LV_BAD;
    for (int i = 0; i < NM; i++) begin
      if (req[i] && levels[i*LW +: LW] != LV_BAD &&
          (!fx_found || levels[i*LW +: LW] < best)) begin
        fx_found = 1'b1;
        fx_win   = IW'(i);
        best     = levels[i*LW +: LW];
      end
    end
  end

  // round robin: first requester after last, wrapping
  always_comb begin
    logic [IW-1:0] j;
    rr_found = 1'b0;
    rr_win   = '0;
    for (int k = 1; k <= NM; k++) begin
      j = last + IW'(k);
      if (!rr_found && req[j]) begin
        rr_found = 1'b1;
        rr_win   = j;
      end
    end
  end

  assign found = rr_mode ? rr_found : fx_found;
  assign win   = rr_mode ? rr_win   : fx_win;
endmodule

// File: rtl/spa_owner.sv
module spa_owner #(
  parameter int unsigned NM  = 8,
  localparam int unsigned IW = $clog2(NM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          found,
  input  logic [IW-1:0] win,
  input  logic          xfer_done,
  output logic          busy,
  output logic [IW-1:0] owner,
  output logic [IW-1:0] last
);
  logic          busy_q, busy_d, arb_en;
  logic [IW-1:0] owner_q, owner_d, last_q, last_d;

  assign arb_en = !busy_q || xfer_done;

  always_comb begin
    busy_d  = found;
    owner_d = found ? win : owner_q;
    last_d  = found ? win : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
      last_q  <= IW'(NM - 1);
    end else if (arb_en) begin
      busy_q  <= busy_d;
      owner_q <= owner_d;
      last_q  <= last_d;
    end
  end

  assign busy  = busy_q;
  assign owner = owner_q;
  assign last  = last_q;
endmodule

// File: rtl/slave_port_arbiter.sv
module slave_port_arbiter #(
  parameter int unsigned NUM_MASTERS = 8,
  parameter int unsigned FIELD_W     = 4,
  parameter int unsigned LEVEL_W     = 3,
  parameter int unsigned DATA_W      = 32,
  localparam int unsigned IDX_W      = $clog2(NUM_MASTERS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic                   cfg_sel,
  input  logic [DATA_W-1:0]      cfg_wdata,
  output logic [DATA_W-1:0]      cfg_rdata,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic                   xfer_done,
  output logic [NUM_MASTERS-1:0] gnt,
  output logic [IDX_W-1:0]       gnt_idx
);
  import spa_pkg::*;

  logic                          rst_meta_n, rst_sync_n;
  logic [NUM_MASTERS*LEVEL_W-1:0] lvl_q;
  logic                          rr_mode, locked, found, busy_q;
  logic [1:0]                    policy;
  logic [IDX_W-1:0]              park_idx, win, owner_q, last_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  spa_regs #(.NM(NUM_MASTERS), .FW(FIELD_W), .LW(LEVEL_W), .DW(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(cfg_wr), .sel(cfg_sel),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .levels(lvl_q), .rr_mode(rr_mode),
    .policy(policy), .park_idx(park_idx), .locked(locked)
  );

  spa_pick #(.NM(NUM_MASTERS), .LW(LEVEL_W)) u_pick (
    .req(req), .levels(lvl_q), .rr_mode(rr_mode), .last(last_q),
    .found(found), .win(win)
  );

  spa_owner #(.NM(NUM_MASTERS)) u_owner (
    .clk(clk), .rst_n(rst_sync_n), .found(found), .win(win),
    .xfer_done(xfer_done), .busy(busy_q), .owner(owner_q), .last(last_q)
  );

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    if (busy_q) begin
      gnt[owner_q] = 1'b1;
      gnt_idx      = owner_q;
    end else if (policy == POL_PARK_FIXED) begin
      gnt[park_idx] = 1'b1;
      gnt_idx       = park_idx;
    end else if (policy == POL_PARK_LAST) begin
      gnt[last_q] = 1'b1;
      gnt_idx     = last_q;
    end
  end
endmodule

// File: rtl/spa_chk.sv
module spa_chk #(
  parameter int unsigned NM  = 8,
  parameter int unsigned LW  = 3,
  localparam int unsigned IW = $clog2(NM)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NM-1:0]    gnt,
  input logic [IW-1:0]    gnt_idx,
  input logic             xfer_done,
  input logic             busy,
  input logic [IW-1:0]    owner,
  input logic [NM*LW-1:0] levels,
  input logic             rr_mode,
  input logic [1:0]       policy,
  input logic             locked
);
  logic [NM*LW-1:0] lvl_prev;
  logic             mode_prev;
  logic [LW-1:0]    owner_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev  <= '0;
      mode_prev <= 1'b1;
    end else begin
      lvl_prev  <= levels;
      mode_prev <= rr_mode;
    end
  end
  assign owner_lvl = lvl_prev[owner*LW +: LW];

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  // R9
  idle_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0) |-> (gnt_idx == '0));
  // R5
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_done) |=> (busy && $stable(gnt_idx)));
  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (locked && $stable(levels) && $stable(policy) && $stable(rr_mode)));
  // R3
  invalid_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !mode_prev) |-> (owner_lvl != '1));
  // R7
  no_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && policy[1]) |-> (gnt == '0));
endmodule

bind slave_port_arbiter spa_chk #(.NM(NUM_MASTERS), .LW(LEVEL_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .gnt(gnt), .gnt_idx(gnt_idx),
  .xfer_done(xfer_done), .busy(busy_q), .owner(owner_q), .levels(lvl_q),
  .rr_mode(rr_mode), .policy(policy), .locked(locked)
);

// File: tb/slave_port_arbiter_tb.sv
module slave_port_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst_n, cfg_wr, cfg_sel, xfer_done;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [7:0]  req, gnt;
  logic [2:0]  gnt_idx;

  int total = 0;
  int fails = 0;
  logic [31:0] cur_prio, cur_ctrl;
  int exp_last;

  always #2.5 clk = ~clk;  // 200 MHz

  slave_port_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req(req),
    .xfer_done(xfer_done), .gnt(gnt), .gnt_idx(gnt_idx)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    req = '0; xfer_done = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    cur_prio = 32'h6654_3210; cur_ctrl = '0; exp_last = 7;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    cfg_sel = sel; cfg_wdata = d; cfg_wr = 1'b1;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic rd_check(input logic sel, input logic [31:0] exp, input string rq);
    cfg_sel = sel; #1;
    check(cfg_rdata == exp, rq, cfg_rdata, exp);
  endtask

  function automatic int fixed_win(logic [7:0] r, logic [31:0] p);
    int w = -1; int best = 8;
    for (int i = 0; i < 8; i++) begin
      int lv = int'(p[4*i +: 3]);
      if (r[i] && lv != 7 && lv < best) begin best = lv; w = i; end
    end
    return w;
  endfunction

  function automatic int rr_win(logic [7:0] r, int last);
    for (int k = 1; k <= 8; k++) if (r[(last + k) % 8]) return (last + k) % 8;
    return -1;
  endfunction

  function automatic logic [7:0] park_gnt(logic [31:0] c, int last);
    case (c[5:4])
      2'b00:   return 8'(1) << c[2:0];
      2'b01:   return 8'(1) << last;
      default: return 8'h00;
    endcase
  endfunction

  // request from idle, check grant, release, check idle value
  task automatic arb_once(input logic [7:0] r, input string rq);
    int w;
    logic [7:0] eg;
    w = cur_ctrl[8] ? rr_win(r, exp_last) : fixed_win(r, cur_prio);
    req = r;
    tick();
    if (w >= 0) begin
      exp_last = w;
      eg = 8'(1) << w;
    end else eg = park_gnt(cur_ctrl, exp_last);
    check(gnt == eg, rq, {24'h0, gnt}, {24'h0, eg});
    check(gnt == '0 || gnt[gnt_idx], "R9 idx", {29'h0, gnt_idx}, {24'h0, eg});
    req = '0; xfer_done = 1'b1;
    tick();
    xfer_done = 1'b0;
    eg = park_gnt(cur_ctrl, exp_last);
    check(gnt == eg, "R7 idle after release", {24'h0, gnt}, {24'h0, eg});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    rd_check(1'b0, 32'h6654_3210, "R1 level reset");
    rd_check(1'b1, 32'h0, "R1 control reset");
    check(gnt == 8'h01, "R1 gnt reset", {24'h0, gnt}, 32'h1);
    check(gnt_idx == 3'd0, "R1 idx reset", {29'h0, gnt_idx}, 32'h0);

    // R2 field masking and positions
    wr(1'b0, 32'hFFFF_FFFF);
    rd_check(1'b0, 32'h7777_7777, "R2 level mask");
    wr(1'b1, 32'h7FFF_FFFF);
    rd_check(1'b1, 32'h0000_0137, "R2 control mask");
    wr(1'b1, 32'h0);
    rd_check(1'b1, 32'h0, "R2 control clear");

    // R3 fixed sweeps under three level maps
    begin
      logic [31:0] maps [3] = '{32'h6654_3210, 32'h0000_0000, 32'h7173_7170};
      foreach (maps[c]) begin
        wr(1'b0, maps[c]);
        cur_prio = maps[c];
        for (int r = 0; r < 256; r++) arb_once(8'(r), "R3 fixed winner");
      end
    end

    // R5 hold until done, re-arbitrate at done
    wr(1'b0, 32'h6654_3210); cur_prio = 32'h6654_3210;
    req = 8'h20; tick();
    check(gnt == 8'h20, "R5 first owner", {24'h0, gnt}, 32'h20);
    req = 8'h24;
    for (int i = 0; i < 3; i++) begin
      tick();
      check(gnt == 8'h20 && gnt_idx == 3'd5, "R5 hold", {24'h0, gnt}, 32'h20);
    end
    req = 8'h04; tick();
    check(gnt == 8'h20, "R5 hold after owner drops", {24'h0, gnt}, 32'h20);
    req = 8'h24; xfer_done = 1'b1; #1;
    check(gnt == 8'h20, "R5 before edge", {24'h0, gnt}, 32'h20);
    tick(); xfer_done = 1'b0;
    check(gnt == 8'h04 && gnt_idx == 3'd2, "R5 handover", {24'h0, gnt}, 32'h04);
    req = '0; xfer_done = 1'b1; tick(); xfer_done = 1'b0;
    exp_last = 2;
    check(gnt == 8'h01, "R7 park master 0", {24'h0, gnt}, 32'h01);

    // R6 latency from idle
    req = 8'h80; #1;
    check(gnt == 8'h01, "R6 not before edge", {24'h0, gnt}, 32'h01);
    tick();
    check(gnt == 8'h80 && gnt_idx == 3'd7, "R6 after edge", {24'h0, gnt}, 32'h80);
    req = '0; xfer_done = 1'b1; tick(); xfer_done = 1'b0;
    exp_last = 7;

    // R4 round robin sweep and rotation
    wr(1'b1, 32'h100); cur_ctrl = 32'h100;
    for (int r = 1; r < 256; r++) arb_once(8'(r), "R4 round robin winner");
    for (int i = 0; i < 10; i++) arb_once(8'hFF, "R4 rotation");
    wr(1'b0, 32'h7777_7777); cur_prio = 32'h7777_7777;
    arb_once(8'h11, "R4 levels ignored");

    // R7 idle policies
    wr(1'b1, 32'h005); cur_ctrl = 32'h005; #1;
    check(gnt == 8'h20 && gnt_idx == 3'd5, "R7 park field", {24'h0, gnt}, 32'h20);
    wr(1'b0, 32'h6654_3210); cur_prio = 32'h6654_3210;
    wr(1'b1, 32'h010); cur_ctrl = 32'h010;
    arb_once(8'h48, "R7 park last grant");
    #1 check(gnt == 8'h08 && gnt_idx == 3'd3, "R7 park last", {24'h0, gnt}, 32'h08);
    wr(1'b1, 32'h027); cur_ctrl = 32'h027; #1;
    check(gnt == 8'h00 && gnt_idx == 3'd0, "R7 R9 no park", {29'h0, gnt_idx}, 32'h0);
    arb_once(8'h60, "R7 grant with no park");
    wr(1'b1, 32'h033); cur_ctrl = 32'h033; #1;
    check(gnt == 8'h00, "R7 policy 11", {24'h0, gnt}, 32'h0);

    // R4 reset value of last grant, then R8 lock
    do_reset();
    wr(1'b1, 32'h100); cur_ctrl = 32'h100;
    arb_once(8'hFF, "R4 first after reset");
    wr(1'b1, 32'h8000_0106); cur_ctrl = 32'h8000_0106;
    rd_check(1'b1, 32'h8000_0106, "R8 lock write stored");
    wr(1'b0, 32'h0);
    rd_check(1'b0, 32'h6654_3210, "R8 level write ignored");
    wr(1'b1, 32'h0);
    rd_check(1'b1, 32'h8000_0106, "R8 control write ignored");
    arb_once(8'h03, "R8 behaviour kept");
    do_reset();
    rd_check(1'b1, 32'h0, "R8 reset clears lock");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule